// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 / Clause 45)

This block is a host-programmed station-management master. It lets software read and write PHY registers over a two-wire MDC/MDIO link, using either Clause 22 framing or Clause 45 indirect framing. Software has two 32-bit registers: a data register and a command register. It loads the data register first. It then writes the command register, and a command write with the busy bit set launches the transaction. The block generates MDC from the host clock at a selectable rate. It shifts the frame out, releases the line for turnaround on reads and samples the PHY's answer. When the frame is finished it clears busy, and after a read it places the returned value in the low half of the data register.

The same register pair serves both clauses. When the Clause 45 enable bit is set, the register field of the command carries the MMD device address instead of a register number. The upper half of the data register then supplies the 16-bit register address, which is sent in a separate address frame ahead of the data frame. A command write with busy clear sends a short burst of MDC clocks with the line released. This lets a PHY that needs MDC edges finish its reset.

Top module: `mdio_master`

## Requirements
- R1: A command write (`reg_sel`=1) with bit 0 set starts a transaction. The busy bit (command bit 0) reads 1 from the next cycle until the frame ends and is the only bit of the command register the host cannot store.
- R2: With clock select field S (command bits 11:8), each MDC half period lasts (S+1)*DIV_UNIT host cycles. Busy stays set for exactly bits*2*(S+1)*DIV_UNIT cycles, where bits is 64 for Clause 22 and 128 for Clause 45. MDC is low whenever busy is clear.
- R3: With command bit 1 clear, one frame is sent: 32 ones, start 01, opcode 10 for a read or 01 for a write, PHY address (bits 25:21), register (bits 20:16), turnaround 10 and data bits 15:0, each field sent MSB first. Host opcode (bits 3:2) 11 selects a read and any other value a write.
- R4: With command bit 1 set, an address frame (start 00, opcode 00, PHY, device from bits 20:16, turnaround 10, data-register bits 31:16) is sent, followed at once by a data frame (start 00, opcode 11 read or 01 write, PHY, device, turnaround 10, data bits 15:0 on writes).
- R5: During a read data frame the output enable drops for the 18 bit times of turnaround and data (frame bits 46 to 63). In all other frame bits the line is driven.
- R6: Read data is sampled on rising MDC edges during frame bits 48 to 63 and lands in data bits 15:0 when busy clears. Data bits 31:16 are unchanged.
- R7: Writes to either register while busy is set are ignored. They do not change the register contents and do not start or extend a frame.
- R8: A command write with bit 0 clear stores the fields and produces 32 MDC cycles with the output enable low. Busy reads 1 for those 64*(S+1)*DIV_UNIT cycles, and the data register is left unchanged.
- R9: MDIO output and enable change only on falling MDC edges or at frame start, never while MDC is high.
- R10: After reset both registers read zero, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the data register, 1 the command register |
| reg_wdata | input | 32 | Write value |
| cmd_rdata | output | 32 | Command register readback, bit 0 is busy |
| data_rdata | output | 32 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
The assertions assume that busy can only rise after a command-register write, and that the host does not change the reset line mid-frame. They also assume MDC activity is owned by the block alone, so an idle line must show MDC low and the pad released. The stimulus is a single host thread that always waits for busy to clear before it reprograms, except in the deliberate R7 case. The PHY model drives `mdio_i` only after a falling MDC edge inside the data field of a read, so sampled values never race the master's rising edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;
  localparam int SEL_W      = 4;
  localparam int PHY_W      = 5;
  localparam int RA_W       = 5;
  localparam int HALF_W     = 16;
  localparam int WAKE_START = 32;
  localparam int TA_FIRST   = 46;
  localparam int RD_FIRST   = 48;

  typedef enum logic [1:0] {
    K_WAKE = 2'd0,
    K_C22  = 2'd1,
    K_C45A = 2'd2,
    K_C45D = 2'd3
  } kind_e;

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [RA_W-1:0]  regad;
    logic [SEL_W-1:0] csel;
    logic [1:0]       op;
    logic             c45;
  } cmd_t;

  function automatic logic [FRAME_BITS-1:0] make_frame(
    input kind_e k, input logic rd, input logic [PHY_W-1:0] phy,
    input logic [RA_W-1:0] ra, input logic [HALF_W-1:0] val);
    logic [1:0] st, opc, ta;
    logic [HALF_W-1:0] body;
    logic rdd;
    rdd  = rd && (k != K_C45A);
    st   = (k == K_C22) ? 2'b01 : 2'b00;
    if (k == K_C45A)      opc = 2'b00;
    else if (k == K_C22)  opc = rd ? 2'b10 : 2'b01;
    else                  opc = rd ? 2'b11 : 2'b01;
    ta   = rdd ? 2'b11 : 2'b10;
    body = rdd ? {HALF_W{1'b1}} : val;
    return {32'hFFFF_FFFF, st, opc, phy, ra, ta, body};
  endfunction

  function automatic logic drive_bit(input kind_e k, input logic rd,
                                     input logic [IDX_W-1:0] idx);
    return (k != K_WAKE) &&
           !(rd && (k != K_C45A) && (idx >= IDX_W'(TA_FIRST)));
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int SEL_W    = 4,
  parameter int DIV_UNIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] csel,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);
  localparam int CNT_W = SEL_W + $clog2(DIV_UNIT + 1) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic             tick;

  always_comb begin
    half   = (CNT_W'(csel) + CNT_W'(1)) * CNT_W'(DIV_UNIT);
    tick   = run && (cnt == half - CNT_W'(1));
    rise_p = tick && !mdc;
    fall_p = tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wake,
  input  logic              c45,
  input  logic              rd,
  input  logic [PHY_W-1:0]  phy,
  input  logic [RA_W-1:0]   ra,
  input  logic [HALF_W-1:0] addr16,
  input  logic [HALF_W-1:0] wdata,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done_rd_p,
  output logic [HALF_W-1:0] rd_val
);
  kind_e                 kind_q;
  logic                  rd_q;
  logic [PHY_W-1:0]      phy_q;
  logic [RA_W-1:0]       ra_q;
  logic [HALF_W-1:0]     wd_q;
  logic [IDX_W-1:0]      bitcnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  last_bit;
  logic [IDX_W-1:0]      bit_nx;

  assign mdio_o    = shreg[FRAME_BITS-1];
  assign last_bit  = (bitcnt == IDX_W'(FRAME_BITS - 1));
  assign bit_nx    = bitcnt + IDX_W'(1);
  assign done_rd_p = active && fall_p && last_bit && rd_q &&
                     (kind_q == K_C22 || kind_q == K_C45D);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      kind_q  <= K_WAKE;
      rd_q    <= 1'b0;
      phy_q   <= '0;
      ra_q    <= '0;
      wd_q    <= '0;
      bitcnt  <= '0;
      shreg   <= '1;
      mdio_oe <= 1'b0;
      rd_val  <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      phy_q  <= phy;
      ra_q   <= ra;
      wd_q   <= wdata;
      if (wake) begin
        kind_q  <= K_WAKE;
        rd_q    <= 1'b0;
        bitcnt  <= IDX_W'(WAKE_START);
        shreg   <= '1;
        mdio_oe <= 1'b0;
      end else if (c45) begin
        kind_q  <= K_C45A;
        rd_q    <= rd;
        bitcnt  <= '0;
        shreg   <= make_frame(K_C45A, rd, phy, ra, addr16);
        mdio_oe <= 1'b1;
      end else begin
        kind_q  <= K_C22;
        rd_q    <= rd;
        bitcnt  <= '0;
        shreg   <= make_frame(K_C22, rd, phy, ra, wdata);
        mdio_oe <= 1'b1;
      end
    end else if (active) begin
      if (rise_p && rd_q && kind_q != K_C45A && kind_q != K_WAKE &&
          bitcnt >= IDX_W'(RD_FIRST)) begin
        rd_val <= {rd_val[HALF_W-2:0], mdio_i};
      end
      if (fall_p) begin
        if (last_bit) begin
          if (kind_q == K_C45A) begin
            kind_q  <= K_C45D;
            bitcnt  <= '0;
            shreg   <= make_frame(K_C45D, rd_q, phy_q, ra_q, wd_q);
            mdio_oe <= 1'b1;
          end else begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
          end
        end else begin
          bitcnt  <= bit_nx;
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
          mdio_oe <= drive_bit(kind_q, rd_q, bit_nx);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_UNIT = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] cmd_rdata,
  output logic [31:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  cmd_t              cmd_q;
  logic [31:0]       data_q;
  logic              busy;
  logic              wr_cmd;
  logic              wr_dat;
  logic              rise_p;
  logic              fall_p;
  logic              done_rd_p;
  logic [HALF_W-1:0] rd_val;
  cmd_t              cmd_in;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:26], reg_wdata[15:12], reg_wdata[7:4]};

  assign wr_cmd = reg_wr_en && reg_sel && !busy;
  assign wr_dat = reg_wr_en && !reg_sel && !busy;

  always_comb begin
    cmd_in.phy   = reg_wdata[25:21];
    cmd_in.regad = reg_wdata[20:16];
    cmd_in.csel  = reg_wdata[11:8];
    cmd_in.op    = reg_wdata[3:2];
    cmd_in.c45   = reg_wdata[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= cmd_in;
      if (wr_dat) data_q <= reg_wdata;
      else if (done_rd_p) data_q[HALF_W-1:0] <= rd_val;
    end
  end

  assign cmd_rdata  = {6'b0, cmd_q.phy, cmd_q.regad, 4'b0, cmd_q.csel,
                       4'b0, cmd_q.op, cmd_q.c45, busy};
  assign data_rdata = data_q;

  mdio_mdc_gen #(.SEL_W(SEL_W), .DIV_UNIT(DIV_UNIT)) u_mdc (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .csel   (cmd_q.csel),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (wr_cmd),
    .wake      (!reg_wdata[0]),
    .c45       (cmd_in.c45),
    .rd        (cmd_in.op == 2'b11),
    .phy       (cmd_in.phy),
    .ra        (cmd_in.regad),
    .addr16    (data_q[31:16]),
    .wdata     (data_q[15:0]),
    .rise_p    (rise_p),
    .fall_p    (fall_p),
    .mdio_i    (mdio_i),
    .active    (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done_rd_p (done_rd_p),
    .rd_val    (rd_val)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic wr_en,
  input logic sel
);
  assert_idle_mdc_low_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  assert_stable_while_high_R9: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_start_from_write_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && sel));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .busy    (cmd_rdata[0]),
  .wr_en   (reg_wr_en),
  .sel     (reg_sel)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] cmd_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // Line monitor: log every bit seen at a rising MDC edge
  logic bit_log [256];
  logic oe_log  [256];
  int   rises = 0;
  int   base  = 0;
  logic [15:0] addr_lat = '0;

  always @(posedge mdc) begin
    bit_log[rises % 256] = mdio_o;
    oe_log[rises % 256]  = mdio_oe;
    rises = rises + 1;
  end

  function automatic logic lg(input int i);
    return bit_log[i % 256];
  endfunction

  // PHY model: latches Clause 45 addresses, answers reads after falling MDC
  int rel, fs, cfs;
  logic [4:0] p5, r5;
  logic [15:0] resp;
  always @(negedge mdc) begin
    rel = (rises - base) % 64;
    fs  = rises - rel;
    if (rel == 0 && rises > base) begin
      cfs = rises - 64;
      if (!lg(cfs+32) && !lg(cfs+33) && !lg(cfs+34) && !lg(cfs+35) &&
          oe_log[(cfs+35) % 256])
        for (int k = 0; k < 16; k++) addr_lat[15-k] = lg(cfs + 48 + k);
    end
    if (rel >= 48) begin
      for (int k = 0; k < 5; k++) begin
        p5[4-k] = lg(fs + 36 + k);
        r5[4-k] = lg(fs + 41 + k);
      end
      resp = {3'b101, p5, 3'b010, r5};
      if (!(lg(fs+32) == 1'b0 && lg(fs+33) == 1'b1)) resp = resp ^ addr_lat;
      mdio_i = resp[63 - rel];
    end else begin
      mdio_i = 1'b1;
    end
  end

  // R9 monitor: data/enable may not move while MDC stays high
  logic pm = 1'b0, po = 1'b1, poe = 1'b0;
  int   r9_viol = 0;
  always @(negedge clk) begin
    if (!rst && mdc && pm && (mdio_o !== po || mdio_oe !== poe))
      r9_viol = r9_viol + 1;
    pm = mdc; po = mdio_o; poe = mdio_oe;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [31:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cmd_word(input logic [4:0] p, input logic [4:0] r,
      input logic [3:0] s, input logic rd, input logic c45, input logic go);
    return {6'b0, p, r, 4'b0, s, 4'b0, (rd ? 2'b11 : 2'b01), c45, go};
  endfunction

  // kind: 0 Clause 22, 1 Clause 45 address, 2 Clause 45 data
  function automatic logic [63:0] exp_frame(input int kind, input logic rd,
      input logic [4:0] p, input logic [4:0] r, input logic [15:0] v);
    logic [1:0] st, op;
    st = (kind == 0) ? 2'b01 : 2'b00;
    op = (kind == 1) ? 2'b00 : (kind == 0) ? (rd ? 2'b10 : 2'b01) : (rd ? 2'b11 : 2'b01);
    return {32'hFFFF_FFFF, st, op, p, r, 2'b10, v};
  endfunction

  function automatic logic [63:0] exp_oe(input int kind, input logic rd);
    return (rd && kind != 1) ? ~64'h3FFFF : '1;
  endfunction

  task automatic cmp_frame(input int f0, input int kind, input logic rd,
      input logic [4:0] p, input logic [4:0] r, input logic [15:0] v, input string tag);
    logic [63:0] ef, eo, af, ao;
    ef = exp_frame(kind, rd, p, r, v);
    eo = exp_oe(kind, rd);
    for (int i = 0; i < 64; i++) begin
      af[63-i] = lg(f0 + i);
      ao[63-i] = oe_log[(f0 + i) % 256];
    end
    check((af & eo) === (ef & eo), tag, af & eo, ef & eo);
    check(ao === eo, "R5 output enable mask", ao, eo);
  endtask

  task automatic run_op(input logic [3:0] s, input logic c45, input logic rd,
      input logic [4:0] p, input logic [4:0] r, input logic [15:0] a, input logic [15:0] w);
    int cyc, nb;
    logic [15:0] ev;
    wr(1'b0, {a, w});
    base = rises;
    wr(1'b1, cmd_word(p, r, s, rd, c45, 1'b1));
    check(cmd_rdata[0] === 1'b1, "R1 busy set after command", cmd_rdata, 1);
    cyc = 0;
    while (cmd_rdata[0]) begin cyc++; @(negedge clk); end
    nb = c45 ? 128 : 64;
    check(cyc == nb * 2 * (s + 1), "R2 busy length from divisor", cyc, nb * 2 * (s + 1));
    check(rises - base == nb, "R2 MDC cycle count", rises - base, nb);
    if (c45) begin
      cmp_frame(base, 1, rd, p, r, a, "R4 address frame");
      cmp_frame(base + 64, 2, rd, p, r, w, "R4 data frame");
    end else begin
      cmp_frame(base, 0, rd, p, r, w, "R3 clause 22 frame");
    end
    ev = rd ? ({3'b101, p, 3'b010, r} ^ (c45 ? a : 16'h0)) : w;
    check(data_rdata === {a, ev}, rd ? "R6 read data" : "R6 write keeps data",
          data_rdata, {a, ev});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    int b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(cmd_rdata === 32'h0, "R10 command reset", cmd_rdata, 0);
    check(data_rdata === 32'h0, "R10 data reset", data_rdata, 0);
    check({mdc, mdio_oe} === 2'b00, "R10 line idle", {mdc, mdio_oe}, 0);

    // Sweep: clock selects x {C22, C45} x {write, read}
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        run_op(4'(s), m[1], m[0], 5'(s * 7 + m * 3 + 1), 5'(31 - s * 5 - m),
               16'(16'h1234 + s * 16'h0111 + m * 16'h0F0F),
               16'(16'hC0DE ^ (s << 4) ^ m));

    // R8: wake burst with busy clear in the command write
    wr(1'b0, 32'hA5A5_5A5A);
    base = rises;
    b0 = rises;
    wr(1'b1, cmd_word(5'd3, 5'd4, 4'd1, 1'b0, 1'b0, 1'b0));
    check(cmd_rdata[0] === 1'b1, "R8 busy during wake", cmd_rdata, 1);
    cyc = 0;
    while (cmd_rdata[0]) begin cyc++; @(negedge clk); end
    check(cyc == 32 * 2 * 2, "R8 wake length", cyc, 128);
    check(rises - b0 == 32, "R8 wake MDC cycles", rises - b0, 32);
    begin
      int drv = 0;
      for (int i = 0; i < 32; i++) if (oe_log[(b0 + i) % 256]) drv++;
      check(drv == 0, "R8 line released in wake", drv, 0);
    end
    check(data_rdata === 32'hA5A5_5A5A, "R8 data untouched", data_rdata, 32'hA5A5_5A5A);
    check(cmd_rdata === {6'b0, 5'd3, 5'd4, 4'b0, 4'd1, 4'b0, 2'b01, 1'b0, 1'b0},
          "R8 fields stored", cmd_rdata, {6'b0, 5'd3, 5'd4, 12'h010, 4'b0100});

    // R7: writes while busy are ignored
    wr(1'b0, 32'h0042_1111);
    base = rises;
    b0 = rises;
    wr(1'b1, cmd_word(5'd9, 5'd2, 4'd0, 1'b0, 1'b0, 1'b1));
    repeat (5) @(negedge clk);
    wr(1'b0, 32'hDEAD_BEEF);
    wr(1'b1, cmd_word(5'd1, 5'd1, 4'd2, 1'b1, 1'b1, 1'b1));
    while (cmd_rdata[0]) @(negedge clk);
    repeat (20) @(negedge clk);
    check(data_rdata === 32'h0042_1111, "R7 data write ignored", data_rdata, 32'h0042_1111);
    check(rises - b0 == 64, "R7 no extra frame", rises - b0, 64);
    check(cmd_rdata === {6'b0, 5'd9, 5'd2, 4'b0, 4'd0, 4'b0, 2'b01, 1'b0, 1'b0},
          "R7 command write ignored", cmd_rdata, {6'b0, 5'd9, 5'd2, 16'h0004});
    cmp_frame(b0, 0, 1'b0, 5'd9, 5'd2, 16'h1111, "R7 frame intact");

    check(r9_viol == 0, "R9 MDIO stable while MDC high", r9_viol, 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule